// File: doc/BRIEF.md
# Serial Flash Configuration Loader

This block is the master side of a configuration load from an external serial flash. After a power-on wait it enables the flash through an active-low select and produces the serial clock. It sends a read instruction followed by a 24-bit start address on its command line, then samples the returned data line once per serial clock. The returned bits are assembled most significant bit first into words, and each completed word is presented on a parallel bus with a one-cycle strobe.

While loading, the block watches a completion input and an active-low error input. A completion that arrives before the whole bitstream has been read, a completion that does not arrive within a short window after the last bit, and an error indication all lead to the same recovery. The block releases the flash, drives its own status output low for a fixed number of cycles, and then begins the load again from the instruction. A valid completion starts a fixed initialization count, after which the user-mode output rises and stays high.

The serial clock comes from the system clock through a divide-by-N enable, so each serial half period lasts exactly `CLK_DIV` system cycles.

Top module: `as_cfg_loader`

## Requirements
- R1: From reset, `flash_cs_n` and `status_n` are 1 and `flash_sck` and `user_mode` are 0. `flash_cs_n` first falls exactly `POR_CYCLES` clock edges after reset is released.
- R2: While `flash_cs_n` is 0, `flash_sck` is low and high for exactly `CLK_DIV` system cycles per half period, and the first rising edge comes `CLK_DIV` cycles after `flash_cs_n` falls. `flash_sck` is 0 whenever `flash_cs_n` is 1.
- R3: The first 32 values of `flash_mosi` sampled at rising `flash_sck` edges are `READ_CMD` (8 bits), then `START_ADDR` (24 bits), each sent MSB first. `flash_mosi` changes only while `flash_sck` is low.
- R4: The next `STREAM_BITS` values of `flash_miso` sampled at rising `flash_sck` edges are packed into words of `WORD_W` bits. The first bit received goes to the MSB. Each word is given with a one-cycle `word_valid` pulse, for `STREAM_BITS/WORD_W` words per load.
- R5: After the last data bit, `flash_sck` stays high for `CLK_DIV` cycles. It then falls in the same cycle that `flash_cs_n` rises, and no further `flash_sck` edges occur.
- R6: If `done_in` is 1 while the instruction or the data is being transferred, the load is abandoned at the next edge: `flash_cs_n` goes to 1, `flash_sck` to 0 and `status_n` to 0. The load then restarts with the instruction.
- R7: If `done_in` is still 0 `DONE_WAIT` edges after `flash_cs_n` rises at the end of the stream, `status_n` falls at that edge and the load restarts.
- R8: `err_n_in` = 0 during transfer, the completion wait or initialization causes the same restart. It takes precedence over `done_in` = 1 in the same cycle.
- R9: `user_mode` rises exactly `INIT_CYCLES` edges after the edge that samples `done_in` = 1 in the completion wait. It then stays 1, with `flash_cs_n` and `status_n` at 1, whatever `done_in` and `err_n_in` do.
- R10: `status_n` stays low for exactly `ERR_CYCLES` cycles with `flash_cs_n` held at 1. `flash_cs_n` falls in the same cycle that `status_n` returns to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flash_cs_n | output | 1 | Active-low flash select |
| flash_sck | output | 1 | Serial clock to the flash |
| flash_mosi | output | 1 | Instruction and address bits to the flash |
| flash_miso | input | 1 | Bitstream from the flash |
| done_in | input | 1 | Load completion indication, active high |
| err_n_in | input | 1 | Error indication, active low |
| status_n | output | 1 | Low while a restart is being signalled |
| word_data | output | WORD_W | Assembled bitstream word |
| word_valid | output | 1 | One-cycle strobe for `word_data` |
| user_mode | output | 1 | High once initialization has finished |

## Verification
The completion check and the error check meet in the completion wait: `done_in` can go high in the very cycle that `err_n_in` drops. The bench waits for the end of the stream and then drives both inputs on the same falling clock edge. It expects `status_n` low after the next edge and `user_mode` never to rise, so the error must win. The bench also raises `done_in` in the middle of a stream while words are being strobed. It then judges that the aborted load produces no late `word_valid` and that the reloaded stream arrives complete and in order.

// File: rtl/as_cfg_pkg.sv
package as_cfg_pkg;

    localparam int CMD_BITS = 32;

    typedef enum logic [2:0] {
        ST_POR,
        ST_CMD,
        ST_READ,
        ST_CHECK,
        ST_INIT,
        ST_USER,
        ST_ERR
    } load_state_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/as_sck_gen.sv
module as_sck_gen #(
    parameter int CLK_DIV = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_in,
    output logic sck,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             sck;
        logic             run;
    } gen_t;

    gen_t gen_d, gen_q;
    logic tick;

    assign tick      = gen_q.run && (gen_q.cnt == DIV_LAST);
    assign rise_tick = tick && !gen_q.sck;
    assign fall_tick = tick && gen_q.sck;
    assign sck       = gen_q.sck;

    always_comb begin
        gen_d     = gen_q;
        gen_d.run = run_in;
        if (!run_in) begin
            gen_d.cnt = '0;
            gen_d.sck = 1'b0;
        end else if (!gen_q.run) begin
            gen_d.cnt = '0;
        end else if (tick) begin
            gen_d.cnt = '0;
            gen_d.sck = !gen_q.sck;
        end else begin
            gen_d.cnt = gen_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gen_q <= '0;
        else        gen_q <= gen_d;
    end

    // R2
    sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_q.run |-> !gen_q.sck);

endmodule

// File: rtl/as_word_pack.sv
module as_word_pack #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              bit_vld,
    input  logic              bit_in,
    output logic [WORD_W-1:0] word,
    output logic              valid
);
    localparam int CW = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(WORD_W - 1);

    typedef struct packed {
        logic [WORD_W-1:0] shift;
        logic [CW-1:0]     cnt;
        logic [WORD_W-1:0] word;
        logic              valid;
    } pack_t;

    pack_t pk_d, pk_q;
    logic [WORD_W-1:0] shifted;

    assign shifted = {pk_q.shift[WORD_W-2:0], bit_in};

    always_comb begin
        pk_d       = pk_q;
        pk_d.valid = 1'b0;
        if (clear) begin
            pk_d.cnt = '0;
        end else if (bit_vld) begin
            pk_d.shift = shifted;
            if (pk_q.cnt == CNT_LAST) begin
                pk_d.cnt   = '0;
                pk_d.word  = shifted;
                pk_d.valid = 1'b1;
            end else begin
                pk_d.cnt = pk_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pk_q <= '0;
        else        pk_q <= pk_d;
    end

    assign word  = pk_q.word;
    assign valid = pk_q.valid;

    // R4
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid || $past(bit_vld));

endmodule

// File: rtl/as_cfg_loader.sv
module as_cfg_loader
    import as_cfg_pkg::*;
#(
    parameter int          CLK_DIV     = 3,
    parameter int          POR_CYCLES  = 10_000_000,
    parameter logic [7:0]  READ_CMD    = 8'h03,
    parameter logic [23:0] START_ADDR  = 24'h000000,
    parameter int          STREAM_BITS = 4096,
    parameter int          WORD_W      = 8,
    parameter int          DONE_WAIT   = 16,
    parameter int          ERR_CYCLES  = 8,
    parameter int          INIT_CYCLES = 136
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              flash_cs_n,
    output logic              flash_sck,
    output logic              flash_mosi,
    input  logic              flash_miso,
    input  logic              done_in,
    input  logic              err_n_in,
    output logic              status_n,
    output logic [WORD_W-1:0] word_data,
    output logic              word_valid,
    output logic              user_mode
);
    localparam int CNT_MAX = max2(max2(POR_CYCLES, DONE_WAIT), max2(ERR_CYCLES, INIT_CYCLES));
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam int BIT_W   = $clog2(max2(STREAM_BITS, CMD_BITS) + 1);
    localparam logic [CNT_W-1:0] POR_LAST  = CNT_W'(POR_CYCLES - 1);
    localparam logic [CNT_W-1:0] WAIT_LAST = CNT_W'(DONE_WAIT - 1);
    localparam logic [CNT_W-1:0] ERR_LAST  = CNT_W'(ERR_CYCLES - 1);
    localparam logic [CNT_W-1:0] INIT_LAST = CNT_W'(INIT_CYCLES - 1);
    localparam logic [BIT_W-1:0] CMD_END   = BIT_W'(CMD_BITS);
    localparam logic [BIT_W-1:0] DATA_END  = BIT_W'(STREAM_BITS);
    localparam logic [CMD_BITS-1:0] CMD_WORD = {READ_CMD, START_ADDR};

    typedef struct packed {
        load_state_e         st;
        logic [CNT_W-1:0]    cnt;
        logic [BIT_W-1:0]    bits;
        logic [CMD_BITS-1:0] sreg;
        logic                mosi;
        logic                cs_n;
        logic                status_n;
        logic                user;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic rise_tick, fall_tick, sck_run, bit_vld, abort;

    function automatic ctl_t enter_cmd(input ctl_t c);
        ctl_t r = c;
        r.st   = ST_CMD;
        r.cnt  = '0;
        r.bits = '0;
        r.mosi = CMD_WORD[CMD_BITS-1];
        r.sreg = CMD_WORD << 1;
        return r;
    endfunction

    function automatic ctl_t enter_err(input ctl_t c);
        ctl_t r = c;
        r.st  = ST_ERR;
        r.cnt = '0;
        return r;
    endfunction

    assign abort = done_in || !err_n_in;

    always_comb begin
        ctl_d   = ctl_q;
        bit_vld = 1'b0;
        case (ctl_q.st)
            ST_POR: begin
                if (ctl_q.cnt == POR_LAST) ctl_d = enter_cmd(ctl_q);
                else                       ctl_d.cnt = ctl_q.cnt + 1'b1;
            end
            ST_CMD: begin
                if (abort) begin
                    ctl_d = enter_err(ctl_q);
                end else begin
                    if (rise_tick) ctl_d.bits = ctl_q.bits + 1'b1;
                    if (fall_tick) begin
                        if (ctl_q.bits == CMD_END) begin
                            ctl_d.st   = ST_READ;
                            ctl_d.bits = '0;
                            ctl_d.mosi = 1'b0;
                        end else begin
                            ctl_d.mosi = ctl_q.sreg[CMD_BITS-1];
                            ctl_d.sreg = ctl_q.sreg << 1;
                        end
                    end
                end
            end
            ST_READ: begin
                if (abort) begin
                    ctl_d = enter_err(ctl_q);
                end else if (rise_tick) begin
                    ctl_d.bits = ctl_q.bits + 1'b1;
                    bit_vld    = 1'b1;
                end else if (fall_tick && ctl_q.bits == DATA_END) begin
                    ctl_d.st  = ST_CHECK;
                    ctl_d.cnt = '0;
                end
            end
            ST_CHECK: begin
                if (!err_n_in)                  ctl_d = enter_err(ctl_q);
                else if (done_in) begin
                    ctl_d.st  = ST_INIT;
                    ctl_d.cnt = '0;
                end
                else if (ctl_q.cnt == WAIT_LAST) ctl_d = enter_err(ctl_q);
                else                             ctl_d.cnt = ctl_q.cnt + 1'b1;
            end
            ST_INIT: begin
                if (!err_n_in)                   ctl_d = enter_err(ctl_q);
                else if (ctl_q.cnt == INIT_LAST) ctl_d.st = ST_USER;
                else                             ctl_d.cnt = ctl_q.cnt + 1'b1;
            end
            ST_USER: ;
            ST_ERR: begin
                if (ctl_q.cnt == ERR_LAST) ctl_d = enter_cmd(ctl_q);
                else                       ctl_d.cnt = ctl_q.cnt + 1'b1;
            end
            default: ctl_d = enter_err(ctl_q);
        endcase
        ctl_d.cs_n     = !(ctl_d.st == ST_CMD || ctl_d.st == ST_READ);
        ctl_d.status_n = (ctl_d.st != ST_ERR);
        ctl_d.user     = (ctl_d.st == ST_USER);
    end

    assign sck_run = !ctl_d.cs_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q          <= '0;
            ctl_q.st       <= ST_POR;
            ctl_q.cs_n     <= 1'b1;
            ctl_q.status_n <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    as_sck_gen #(.CLK_DIV(CLK_DIV)) sck_gen_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_in    (sck_run),
        .sck       (flash_sck),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    as_word_pack #(.WORD_W(WORD_W)) word_pack_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (ctl_q.cs_n),
        .bit_vld (bit_vld),
        .bit_in  (flash_miso),
        .word    (word_data),
        .valid   (word_valid)
    );

    assign flash_cs_n = ctl_q.cs_n;
    assign flash_mosi = ctl_q.mosi;
    assign status_n   = ctl_q.status_n;
    assign user_mode  = ctl_q.user;

    // R2
    sck_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flash_sck |-> !flash_cs_n);

    // R3
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_sck && $past(flash_sck)) |-> $stable(flash_mosi));

    // R4
    valid_in_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> !flash_cs_n);

    // R10
    err_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !status_n |-> flash_cs_n);

    // R9
    user_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        user_mode |=> user_mode && status_n && flash_cs_n);

endmodule

// File: tb/as_cfg_loader_tb_top.sv
module as_cfg_loader_tb_top;
    localparam int          CLK_DIV     = 3;
    localparam int          POR_CYCLES  = 40;
    localparam logic [7:0]  READ_CMD    = 8'h0B;
    localparam logic [23:0] START_ADDR  = 24'h00A5C3;
    localparam int          STREAM_BITS = 64;
    localparam int          WORD_W      = 8;
    localparam int          DONE_WAIT   = 16;
    localparam int          ERR_CYCLES  = 8;
    localparam int          INIT_CYCLES = 136;
    localparam int          NWORDS      = STREAM_BITS / WORD_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flash_miso = 1'b0;
    logic done_in = 1'b0;
    logic err_n_in = 1'b1;
    logic flash_cs_n, flash_sck, flash_mosi, status_n, word_valid, user_mode;
    logic [WORD_W-1:0] word_data;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    as_cfg_loader #(
        .CLK_DIV(CLK_DIV), .POR_CYCLES(POR_CYCLES), .READ_CMD(READ_CMD),
        .START_ADDR(START_ADDR), .STREAM_BITS(STREAM_BITS), .WORD_W(WORD_W),
        .DONE_WAIT(DONE_WAIT), .ERR_CYCLES(ERR_CYCLES), .INIT_CYCLES(INIT_CYCLES)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .flash_cs_n(flash_cs_n), .flash_sck(flash_sck),
        .flash_mosi(flash_mosi), .flash_miso(flash_miso), .done_in(done_in),
        .err_n_in(err_n_in), .status_n(status_n), .word_data(word_data),
        .word_valid(word_valid), .user_mode(user_mode)
    );

    // ---------------- flash model ----------------
    logic [7:0]  seed = 8'h00;
    logic [31:0] cmd_rx = '0;
    int          fbits = 0;
    int          dcnt = 0;
    int          sck_rises = 0;

    function automatic logic [7:0] fbyte(input int k, input logic [7:0] s);
        return 8'((k * 53 + 17)) ^ s;
    endfunction

    always @(posedge flash_sck or posedge flash_cs_n) begin
        if (flash_cs_n) fbits <= 0;
        else begin
            if (fbits < 32) cmd_rx <= {cmd_rx[30:0], flash_mosi};
            fbits <= fbits + 1;
        end
    end

    always @(negedge flash_sck or posedge flash_cs_n) begin
        if (flash_cs_n) dcnt <= 0;
        else if (fbits >= 32) begin
            flash_miso <= fbyte(dcnt / 8, seed)[7 - (dcnt % 8)];
            dcnt <= dcnt + 1;
        end
    end

    always @(posedge flash_sck) sck_rises <= sck_rises + 1;

    // ---------------- observers ----------------
    logic [WORD_W-1:0] got [NWORDS];
    int   wcount = 0;
    int   dbl_valid = 0;
    logic prev_valid = 1'b0;
    bit   meas_en = 1'b0;
    int   bad_width = 0;
    int   run_len = 0;
    logic last_sck = 1'b0;

    always @(negedge clk) begin
        if (word_valid) begin
            if (prev_valid) dbl_valid++;
            if (wcount < NWORDS) got[wcount] = word_data;
            wcount++;
        end
        prev_valid = word_valid;
        if (meas_en && !flash_cs_n) begin
            if (flash_sck == last_sck) run_len++;
            else begin
                if (run_len != CLK_DIV) bad_width++;
                run_len = 1;
            end
            last_sck = flash_sck;
        end else begin
            run_len  = 0;
            last_sck = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; done_in = 1'b0; err_n_in = 1'b1;
        repeat (3) @(negedge clk);
        wcount = 0; dbl_valid = 0;
        rst_n = 1'b1;
    endtask

    task automatic wait_cs(input logic lvl);
        int guard = 0;
        while (flash_cs_n != lvl && guard < 5000) begin
            @(negedge clk); guard++;
        end
    endtask

    task automatic check_stream(input string req);
        chk(wcount == NWORDS, req, wcount, NWORDS);
        for (int k = 0; k < NWORDS; k++)
            chk(got[k] == fbyte(k, seed), req, int'(got[k]), int'(fbyte(k, seed)));
        chk(dbl_valid == 0, req, dbl_valid, 0);
    endtask

    // R1, R2, R3, R4, R5, R9
    task automatic t_normal(input logic [7:0] s);
        int n, r0;
        seed = s;
        do_reset();
        @(negedge clk);
        chk(flash_cs_n && status_n && !flash_sck && !user_mode, "R1 reset state", 0, 1);
        n = 1;
        while (flash_cs_n && n < 1000) begin @(negedge clk); n++; end
        chk(n == POR_CYCLES, "R1 por delay", n, POR_CYCLES);
        meas_en = 1'b1;
        wait_cs(1'b1);
        meas_en = 1'b0;
        chk(bad_width == 0, "R2 sck half period", bad_width, 0);
        chk(cmd_rx == {READ_CMD, START_ADDR}, "R3 instruction and address",
            int'(cmd_rx), int'({READ_CMD, START_ADDR}));
        check_stream("R4 words");
        chk(!flash_sck, "R5 sck low at end", int'(flash_sck), 0);
        r0 = sck_rises;
        done_in = 1'b1;
        repeat (INIT_CYCLES) @(posedge clk);
        @(negedge clk);
        chk(!user_mode, "R9 user mode not early", int'(user_mode), 0);
        @(posedge clk);
        @(negedge clk);
        chk(user_mode, "R9 user mode on time", int'(user_mode), 1);
        chk(sck_rises == r0, "R5 no sck after end", sck_rises - r0, 0);
        done_in = 1'b0; err_n_in = 1'b0;
        repeat (5) @(negedge clk);
        chk(user_mode && status_n && flash_cs_n, "R9 inputs ignored in user mode", 0, 1);
        err_n_in = 1'b1;
    endtask

    task automatic measure_err(input string req);
        int n = 0;
        while (!status_n && n < 100) begin
            chk(flash_cs_n, "R10 cs high during status", int'(flash_cs_n), 1);
            @(negedge clk); n++;
        end
        chk(n == ERR_CYCLES, "R10 status width", n, ERR_CYCLES);
        chk(!flash_cs_n, {req, " / R10 reselect"}, int'(flash_cs_n), 0);
    endtask

    // R6, R10
    task automatic t_early_done();
        seed = 8'h5A;
        do_reset();
        wait_cs(1'b0);
        while (dcnt < 20) @(negedge clk);
        done_in = 1'b1;
        @(posedge clk);
        @(negedge clk);
        done_in = 1'b0;
        chk(!status_n && flash_cs_n && !flash_sck, "R6 early done aborts", int'(status_n), 0);
        measure_err("R6");
        wcount = 0;
        wait_cs(1'b1);
        chk(cmd_rx == {READ_CMD, START_ADDR}, "R6 instruction resent",
            int'(cmd_rx), int'({READ_CMD, START_ADDR}));
        check_stream("R6 reload");
    endtask

    // R7
    task automatic t_missing_done();
        int k = 0;
        seed = 8'hC3;
        do_reset();
        wait_cs(1'b0);
        wait_cs(1'b1);
        while (status_n && k < 100) begin @(negedge clk); k++; end
        chk(k == DONE_WAIT, "R7 missing done timeout", k, DONE_WAIT);
        measure_err("R7");
    endtask

    // R8
    task automatic t_error_in();
        seed = 8'h11;
        do_reset();
        wait_cs(1'b0);
        repeat (30) @(negedge clk);
        err_n_in = 1'b0;
        @(posedge clk);
        @(negedge clk);
        err_n_in = 1'b1;
        chk(!status_n && flash_cs_n, "R8 error during transfer", int'(status_n), 0);
        measure_err("R8");
        wait_cs(1'b1);
        done_in = 1'b1; err_n_in = 1'b0;
        @(posedge clk);
        @(negedge clk);
        done_in = 1'b0; err_n_in = 1'b1;
        chk(!status_n, "R8 error beats done", int'(status_n), 0);
        repeat (INIT_CYCLES + 4) @(negedge clk);
        chk(!user_mode, "R8 no user mode after error", int'(user_mode), 0);
    endtask

    initial begin
        t_normal(8'h00);
        t_normal(8'hA7);
        t_early_done();
        t_missing_done();
        t_error_in();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule